// File: doc/BRIEF.md
# Self-Recovering 32-Stage Fibonacci Pseudo-Random Generator

This block is a 32-stage Fibonacci shift register that produces a maximal-length pseudo-random bit stream. On every rising clock edge each stage hands its value to the next stage up. A new bit enters the first stage from one of three places. The first is the XOR of four tapped stages. The second is a forced one, used when the register holds nothing but zeros. The third is a data bit that the user drives from outside.

The manual path serves two purposes. The user can shift in any starting pattern, and the user can empty the register on purpose. Once the select line returns to feedback, the zero detector pushes a one into the first stage. The sequence therefore restarts by itself and cannot stay stuck at zero. The eight highest stages are brought out in parallel, and the top stage doubles as the serial stream. A synchronous active-high reset empties all stages.

Top module: `prbs_zero_escape`

## Requirements
- R1: On a clock edge with `rst` high, all 32 stages become zero, so `tap_out` reads 8'h00 after that edge.
- R2: On every edge without reset, stage n (n = 1..31) passes its value to stage n+1, and stage 32 is shifted out and discarded.
- R3: With `manual_sel` low and at least one stage set, the new stage-1 value is the XOR of stages 32, 30, 26 and 25.
- R4: With `manual_sel` low and every stage zero, stage 1 takes the value 1 at the next edge, so the register holds all zeros for no more than one cycle.
- R5: With `manual_sel` high, stage 1 takes `manual_bit` at the next edge. This overrides both the feedback and the forced one, so repeated zeros keep the register empty for as long as the select stays high.
- R6: `tap_out[k]` carries stage 25+k for k = 0..7. Bit 0 is stage 25 and bit 7 is stage 32, which is the serial output.
- R7: Starting from an all-zero register with `manual_sel` low, `tap_out` reads 8'h00 for 24 edges. It reads 8'h01 after the 25th edge and 8'h80 after the 32nd edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages shift on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all stages |
| manual_sel | input | 1 | 1: stage 1 loads `manual_bit`; 0: stage 1 loads the feedback or the forced one |
| manual_bit | input | 1 | External bit loaded into stage 1 when `manual_sel` is high |
| tap_out | output | 8 | Stages 25..32, with stage 25 on bit 0 |

## Verification
The zero-escape and the manual load both compete for stage 1 in the same cycle whenever the register is empty and the select is high. The bench sets up this collision by zeroizing the register with `manual_bit` at 0 for forty edges. It checks that the outputs stay at zero the whole time, which shows that the manual bit wins. It then lowers the select and checks that the forced one appears at stage 25 exactly 25 edges later. A mixed sweep also toggles the select and data bits against a cycle-exact model in the bench, so that the two paths meet at both full and empty register states.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    localparam int unsigned LFSR_W   = 32;
    localparam int unsigned TAP_W    = 8;
    localparam int unsigned DET_GRP  = 8;

    // Taps at stages 32, 30, 26, 25 (bit index = stage - 1)
    localparam logic [LFSR_W-1:0] TAP_MASK = 32'hA300_0000;

    typedef enum logic [1:0] {
        SRC_FEEDBACK = 2'd0,
        SRC_ESCAPE   = 2'd1,
        SRC_MANUAL   = 2'd2
    } feed_src_e;

    typedef struct packed {
        feed_src_e src;
        logic      value;
    } feed_t;

    function automatic logic tap_parity(input logic [LFSR_W-1:0] s,
                                        input logic [LFSR_W-1:0] m);
        return ^(s & m);
    endfunction

endpackage

// File: rtl/lfsr_zero_detect.sv
module lfsr_zero_detect #(
    parameter int unsigned W   = lfsr_pkg::LFSR_W,
    parameter int unsigned GRP = lfsr_pkg::DET_GRP
) (
    input  logic [W-1:0] state,
    output logic         is_zero
);
    localparam int unsigned N_GRP = W / GRP;

    logic [N_GRP-1:0] grp_any;

    // Two-level NOR: per-group OR, then a final NOR across the groups
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_any[g] = |state[g*GRP +: GRP];
    end

    assign is_zero = ~|grp_any;

endmodule

// File: rtl/lfsr_feed_select.sv
module lfsr_feed_select
    import lfsr_pkg::*;
#(
    parameter int unsigned         W    = LFSR_W,
    parameter logic [LFSR_W-1:0]   TAPS = TAP_MASK
) (
    input  logic [W-1:0] state,
    input  logic         is_zero,
    input  logic         manual_sel,
    input  logic         manual_bit,
    output feed_t        feed
);
    always_comb begin
        if (manual_sel) begin
            feed.src   = SRC_MANUAL;
            feed.value = manual_bit;
        end else if (is_zero) begin
            feed.src   = SRC_ESCAPE;
            feed.value = 1'b1;
        end else begin
            feed.src   = SRC_FEEDBACK;
            feed.value = tap_parity(LFSR_W'(state), TAPS);
        end
    end

endmodule

// File: rtl/lfsr_shift_reg.sv
module lfsr_shift_reg #(
    parameter int unsigned W = lfsr_pkg::LFSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_bit,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= {state[W-2:0], in_bit};
    end

    // R1: reset empties every stage
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (state == '0));

    // R2: each stage moves up by one
    a_r2_stage_shift: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state[W-1:1] == $past(state[W-2:0])));

endmodule

// File: rtl/prbs_zero_escape.sv
module prbs_zero_escape
    import lfsr_pkg::*;
#(
    parameter int unsigned W     = LFSR_W,
    parameter int unsigned OUT_W = TAP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             manual_sel,
    input  logic             manual_bit,
    output logic [OUT_W-1:0] tap_out
);
    localparam int unsigned OUT_LSB = W - OUT_W;

    logic [W-1:0] state;
    logic         is_zero;
    feed_t        feed;

    lfsr_zero_detect #(.W(W), .GRP(DET_GRP)) u_det (
        .state   (state),
        .is_zero (is_zero)
    );

    lfsr_feed_select #(.W(W), .TAPS(TAP_MASK)) u_sel (
        .state      (state),
        .is_zero    (is_zero),
        .manual_sel (manual_sel),
        .manual_bit (manual_bit),
        .feed       (feed)
    );

    lfsr_shift_reg #(.W(W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .in_bit (feed.value),
        .state  (state)
    );

    // R6: the highest OUT_W stages, stage 25 on bit 0
    assign tap_out = state[W-1:OUT_LSB];

    // R3: feedback parity enters stage 1
    a_r3_tap_feedback: assert property (@(posedge clk) disable iff (rst)
        (!manual_sel && state != '0) |=> (state[0] == $past(^(state & TAP_MASK))));

    // R4: an empty register leaves zero after one edge
    a_r4_zero_escape: assert property (@(posedge clk) disable iff (rst)
        (!manual_sel && state == '0) |=> (state == W'(1)));

    // R5: manual bit wins over every other source
    a_r5_manual_load: assert property (@(posedge clk) disable iff (rst)
        manual_sel |=> (state[0] == $past(manual_bit)));

endmodule

// File: tb/prbs_zero_escape_test.sv
module prbs_zero_escape_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       manual_sel = 1'b0;
    logic       manual_bit = 1'b0;
    logic [7:0] tap_out;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    logic [31:0] model = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    prbs_zero_escape uut (
        .clk        (clk),
        .rst        (rst),
        .manual_sel (manual_sel),
        .manual_bit (manual_bit),
        .tap_out    (tap_out)
    );

    function automatic logic [31:0] next_model(logic [31:0] s, logic r, logic sel, logic d);
        logic nb;
        if (r) return '0;
        if (sel)            nb = d;
        else if (s == '0)   nb = 1'b1;
        else                nb = s[31] ^ s[29] ^ s[25] ^ s[24];
        return {s[30:0], nb};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: tap_out=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic tick(logic r, logic sel, logic d);
        rst = r; manual_sel = sel; manual_bit = d;
        model = next_model(model, r, sel, d);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] pat;
        logic [31:0] stim;
        @(negedge clk);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        check("R1 reset", tap_out, 8'h00);

        // R7 / R4 / R6: restart from empty register
        for (int i = 1; i <= 32; i++) begin
            tick(1'b0, 1'b0, 1'b0);
            if (i < 25)       check("R7 quiet", tap_out, 8'h00);
            else if (i == 25) check("R7 first one at stage 25", tap_out, 8'h01);
            else              check("R6 walk", tap_out, 8'h01 << (i - 25));
        end

        // R2 / R5: load a pattern through the manual path
        pat = 32'hA5C3_1E77;
        for (int i = 31; i >= 0; i--) begin
            tick(1'b0, 1'b1, pat[i]);
            check("R2 manual shift", tap_out, model[31:24]);
        end
        check("R5 pattern loaded", tap_out, pat[31:24]);

        // R3: long feedback run
        for (int i = 0; i < 5000; i++) begin
            tick(1'b0, 1'b0, 1'b0);
            check("R3 feedback", tap_out, model[31:24]);
        end

        // R5 vs R4: zeroize with select high, hold empty
        for (int i = 0; i < 40; i++) begin
            tick(1'b0, 1'b1, 1'b0);
            if (i >= 32) check("R5 held empty", tap_out, 8'h00);
        end
        for (int i = 1; i <= 25; i++) begin
            tick(1'b0, 1'b0, 1'b0);
            if (i == 24) check("R7 still empty", tap_out, 8'h00);
            if (i == 25) check("R4 escape reached stage 25", tap_out, 8'h01);
        end

        // R1: reset in mid-run
        for (int i = 0; i < 100; i++) tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        check("R1 mid-run reset", tap_out, 8'h00);

        // Mixed sweep of modes and data (R3 R4 R5)
        stim = 32'h1357_9BDF;
        for (int i = 0; i < 2000; i++) begin
            stim = {stim[30:0], stim[31] ^ stim[21] ^ stim[1] ^ stim[0]};
            tick(1'b0, stim[3] & stim[7], stim[11]);
            check("R5 mixed sweep", tap_out, model[31:24]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule